// File: doc/BRIEF.md
# Pre-encoded radix-4 Booth multiplier

This block multiplies a two's complement operand by a coefficient that arrives already recoded into radix-4 signed digits. Each digit is carried as a three-bit triplet (sign, magnitude-one, magnitude-two), so the coefficient bus is 3N/2 bits wide. No Booth recoder is needed at run time. The coefficient is meant to come from a table that was encoded ahead of time. The block itself only selects the partial products, reduces them and delivers the product.

For every digit, a partial product of N+1 bits is selected from the operand: the operand itself, the operand shifted left by one bit, or zero, with all bits inverted when the digit is negative. The partial products are weighted by powers of four and sign extended. They go into a carry-save reduction tree with one extra row that holds the per-digit +1 corrections for the inverted rows. A carry-propagate adder merges the two remaining rows. The 2N-bit product is registered together with a valid flag.

The encoder stores a negative zero (bit pattern 111) with a cleared sign bit. Because of this, the correction bit of each digit is the stored sign bit itself.

Top module: `pbm_mult`

## Requirements
- R1: Digit j of the coefficient occupies `coef_in[3j+2:3j]`: bit 3j+2 is the sign (1 = negative), bit 3j+1 means magnitude 2 and bit 3j means magnitude 1. The digit value is ±(mag1 + 2·mag2). The coefficient value is the sum of digit_j·4^j. A legal triplet never sets both magnitude bits, and never sets the sign without a magnitude bit.
- R2: For legal input, `prod_out` equals the signed product of `a_in` and the coefficient value, as a 2N-bit two's complement number.
- R3: `prod_out` and `out_valid` are updated at the rising edge that samples `in_valid` high. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and back-to-back inputs give back-to-back results.
- R4: While `in_valid` is low, `a_in` and `coef_in` are ignored and `prod_out` keeps its last value.
- R5: A low `rst_n` at a rising edge clears `prod_out` to zero and `out_valid` to 0.
- R6: The most negative operand, -2^(N-1), multiplies correctly, including by digits of magnitude 2 (the operand is sign extended by one bit above its MSB).
- R7: The most negative coefficient, whose top digit is -2, multiplies correctly; with both inputs at their most negative value the product is 2^(2N-2).
- R8: A zero digit encoded 000 contributes nothing; the all-ones coefficient (every upper digit zero, lowest digit -1) yields the negated operand.
- R9: The correction bit of each negative digit exactly cancels its inverted row, so a zero operand gives a zero product for any coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| a_in | input | N | Two's complement operand |
| coef_in | input | 3N/2 | Pre-encoded coefficient, one triplet per digit |
| out_valid | output | 1 | `prod_out` holds a new product |
| prod_out | output | 2N | Registered signed product |

## Verification
Every product is due at the rising edge that samples `in_valid`, so it is visible one cycle after the operands are applied. The bench changes its inputs on falling edges and reads `prod_out` and `out_valid` on the next falling edge. Each result is therefore compared exactly one clock after its stimulus. Idle cycles use random junk on the operand buses, and the bench checks that the held product did not move. Reset is checked both from power-up and in the middle of a stream.

// File: rtl/pbm_pkg.sv
// Package: shared digit type and elaboration-time helpers for the
// pre-encoded Booth multiplier. Assumes N is even.
package pbm_pkg;

    // One radix-4 digit as it is stored: sign, magnitude 2, magnitude 1.
    typedef struct packed {
        logic neg;
        logic mag2;
        logic mag1;
    } bdigit_t;

    // Number of 3:2 levels needed to bring `rows` operands down to two.
    function automatic int csa_levels(input int rows);
        int r;
        int l;
        r = rows;
        l = 0;
        while (r > 2) begin
            r = 2 * (r / 3) + (r % 3);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/pbm_ppgen.sv
// Partial product selector for one pre-encoded radix-4 digit.
// Produces N+1 bits: the operand, the operand doubled, or zero, with every
// bit inverted for a negative digit. The +1 that completes the negation is
// added elsewhere. Assumes a legal triplet (magnitude bits not both set).
module pbm_ppgen
    import pbm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  bdigit_t      dig_i,
    output logic [N:0]   pp_o
);

    // Operand with a zero below bit 0 and a sign copy above bit N-1.
    logic [N+1:0] a_ext;
    assign a_ext = {a_i[N-1], a_i, 1'b0};

    // One selector per output bit; ext index i+1 is a[i], index i is a[i-1].
    for (genvar i = 0; i <= N; i++) begin : g_bit
        assign pp_o[i] = ((dig_i.mag1 & a_ext[i+1]) | (dig_i.mag2 & a_ext[i])) ^ dig_i.neg;
    end

endmodule

// File: rtl/pbm_csa_tree.sv
// Carry-save reduction tree: compresses ROWS operands of W bits into a sum
// row and a carry row with levels of 3:2 counters. Arithmetic is modulo 2^W.
// Assumes ROWS >= 2.
module pbm_csa_tree
    import pbm_pkg::*;
#(
    parameter int ROWS = 9,
    parameter int W    = 32
) (
    input  logic [W-1:0] rows_i [ROWS],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    localparam int LEVELS = csa_levels(ROWS);

    logic [W-1:0] cur [ROWS];
    logic [W-1:0] nxt [ROWS];
    int           cnt;
    int           ncnt;

    // Level-by-level 3:2 compression; leftover rows pass to the next level.
    always_comb begin
        cur  = rows_i;
        cnt  = ROWS;
        nxt  = '{default: '0};
        ncnt = 0;
        for (int l = 0; l < LEVELS; l++) begin
            nxt  = '{default: '0};
            ncnt = 0;
            for (int g = 0; g < ROWS / 3; g++) begin
                if (3 * g + 2 < cnt) begin
                    nxt[ncnt]     = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                    nxt[ncnt + 1] = ((cur[3*g] & cur[3*g+1]) |
                                     (cur[3*g] & cur[3*g+2]) |
                                     (cur[3*g+1] & cur[3*g+2])) << 1;
                    ncnt = ncnt + 2;
                end
            end
            for (int r = 0; r < ROWS; r++) begin
                if (r >= 3 * (cnt / 3) && r < cnt) begin
                    nxt[ncnt] = cur[r];
                    ncnt = ncnt + 1;
                end
            end
            cur = nxt;
            cnt = ncnt;
        end
        sum_o   = cur[0];
        carry_o = cur[1];
    end

endmodule

// File: rtl/pbm_mult.sv
// Pre-encoded radix-4 Booth multiplier, top level.
// Takes an N-bit two's complement operand and a coefficient given as N/2
// signed-digit triplets, and registers the 2N-bit product one cycle later.
// Assumes: N even, 4 <= N <= 32; triplets are legal, with negative zero
// stored with a cleared sign, so each correction bit is the sign bit.
module pbm_mult
    import pbm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [N-1:0]         a_in,
    input  logic [3*(N/2)-1:0]   coef_in,
    output logic                 out_valid,
    output logic [2*N-1:0]       prod_out
);

    localparam int K    = N / 2;
    localparam int PW   = 2 * N;
    localparam int ROWS = K + 1;

    bdigit_t        dig   [K];
    logic [N:0]     pp    [K];
    logic [PW-1:0]  rows  [ROWS];
    logic [PW-1:0]  cor;
    logic [PW-1:0]  t_sum;
    logic [PW-1:0]  t_carry;
    logic [PW-1:0]  prod_c;

    // One selector per digit, each row weighted by 4^j and sign extended.
    for (genvar j = 0; j < K; j++) begin : g_digit
        assign dig[j] = bdigit_t'(coef_in[3*j +: 3]);

        pbm_ppgen #(.N(N)) u_ppgen (
            .a_i   (a_in),
            .dig_i (dig[j]),
            .pp_o  (pp[j])
        );

        assign rows[j] = {{(PW-N-1){pp[j][N]}}, pp[j]} << (2 * j);

        // R1: stored triplets are legal (no 3 and no negative zero)
        a_r1_legal_triplet: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (!(dig[j].mag1 && dig[j].mag2) &&
                          !(dig[j].neg && !dig[j].mag1 && !dig[j].mag2)));

        // R9: inverted row plus its correction bit equals digit times operand
        a_r9_row_value: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |->
            (longint'($signed(pp[j])) + longint'(dig[j].neg)) ==
            ((dig[j].neg ? -1 : 1) * (dig[j].mag2 ? 2 : (dig[j].mag1 ? 1 : 0)) *
             longint'($signed(a_in))));
    end

    // Correction row: the sign bit of digit j lands at weight 4^j.
    always_comb begin
        cor = '0;
        for (int j = 0; j < K; j++) begin
            cor[2*j] = dig[j].neg;
        end
    end

    assign rows[K] = cor;

    pbm_csa_tree #(.ROWS(ROWS), .W(PW)) u_tree (
        .rows_i  (rows),
        .sum_o   (t_sum),
        .carry_o (t_carry)
    );

    // Final carry-propagate merge of the two tree rows.
    assign prod_c = t_sum + t_carry;

    // Output register: loads on valid input, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod_out <= prod_c;
            end
        end
    end

    // Reference value of digit-times-operand sums, used only by assertions.
    logic [PW-1:0] chk_prod;
    always_comb begin
        longint acc;
        acc = 0;
        for (int j = 0; j < K; j++) begin
            acc = acc + (longint'((dig[j].neg ? -1 : 1) *
                                  (dig[j].mag2 ? 2 : (dig[j].mag1 ? 1 : 0)))
                         * longint'($signed(a_in))) * (longint'(1) <<< (2 * j));
        end
        chk_prod = PW'(acc);
    end

    // R2: registered product equals the digit-weighted product
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_out == $past(chk_prod));

    // R3: valid output follows valid input by one cycle
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: product holds while no input is valid
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod_out));

    // R5: reset clears both outputs
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && prod_out == '0));

endmodule

// File: tb/pbm_mult_tb.sv
// Self-checking bench for pbm_mult: directed corners plus seeded random.
module pbm_mult_tb;

    localparam int N  = 16;
    localparam int K  = N / 2;
    localparam int CW = 3 * K;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  a_in = '0;
    logic [CW-1:0] coef_in = '0;
    logic          out_valid;
    logic [PW-1:0] prod_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pbm_mult #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .coef_in   (coef_in),
        .out_valid (out_valid),
        .prod_out  (prod_out)
    );

    // Off-line encoder per R1: window {b[2j+1],b[2j],b[2j-1]}, b[-1]=0,
    // triplet {neg,mag2,mag1}; pattern 111 is stored as 000.
    function automatic logic [CW-1:0] encode(input logic [N-1:0] b);
        logic [CW-1:0] c;
        logic [N:0]    bx;
        logic [2:0]    w;
        c  = '0;
        bx = {b, 1'b0};
        for (int j = 0; j < K; j++) begin
            w = bx[2*j +: 3];
            case (w)
                3'b001, 3'b010: c[3*j +: 3] = 3'b001;
                3'b011:         c[3*j +: 3] = 3'b010;
                3'b100:         c[3*j +: 3] = 3'b110;
                3'b101, 3'b110: c[3*j +: 3] = 3'b101;
                default:        c[3*j +: 3] = 3'b000;
            endcase
        end
        return c;
    endfunction

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [PW-1:0] sa;
        logic signed [PW-1:0] sb;
        sa = $signed({{N{a[N-1]}}, a});
        sb = $signed({{N{b[N-1]}}, b});
        return PW'(sa * sb);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Apply one operand pair on a falling edge and check one clock later.
    task automatic mul(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
        in_valid = 1'b1;
        a_in     = a;
        coef_in  = encode(b);
        @(negedge clk);
        check(req, prod_out, ref_mul(a, b));
        check({req, " valid"}, PW'(out_valid), PW'(1));
    endtask

    // Idle cycle with junk operands: R4 hold and R3 no valid.
    task automatic idle();
        logic [PW-1:0] held;
        held     = prod_out;
        in_valid = 1'b0;
        a_in     = N'($urandom);
        coef_in  = encode(N'($urandom));
        @(negedge clk);
        check("R4 hold", prod_out, held);
        check("R3 idle valid", PW'(out_valid), PW'(0));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    localparam logic [N-1:0] MAXN = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXP = {1'b0, {(N-1){1'b1}}};

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5 reset prod", prod_out, '0);
        check("R5 reset valid", PW'(out_valid), PW'(0));
        rst_n = 1'b1;
        @(negedge clk);

        mul("R2 small", 16'd3, 16'd5);
        mul("R2 mixed sign", 16'hFFF9, 16'd1234);
        mul("R6 min a * 2", MAXN, 16'd2);
        mul("R6 min a * max", MAXN, MAXP);
        mul("R7 min coef", 16'd7, MAXN);
        mul("R7 both min", MAXN, MAXN);
        check("R7 both min value", prod_out, PW'(1) << (PW - 2));
        mul("R8 all ones coef", 16'h1234, 16'hFFFF);
        check("R8 negated a", prod_out, PW'(-32'sd4660));
        mul("R8 zero coef", 16'hBEEF, 16'h0000);
        mul("R9 zero a neg coef", 16'h0000, 16'hA5A5);
        mul("R9 zero a min coef", 16'h0000, MAXN);
        mul("R2 max*max", MAXP, MAXP);
        idle();
        idle();

        // R3: back-to-back and mixed random stream
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 5) == 0) idle();
            else mul("R3 R2 random", N'($urandom), N'($urandom));
        end

        // R5: reset in mid-stream
        mul("R2 before reset", 16'd100, 16'd200);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R5 mid reset prod", prod_out, '0);
        check("R5 mid reset valid", PW'(out_valid), PW'(0));
        rst_n = 1'b1;
        mul("R2 after reset", 16'hFFFF, 16'hFFFF);
        idle();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog act=timeout exp=finished");
        summary();
    end

endmodule